// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar in binary-coded decimal. It counts seconds, minutes, hours, day of month, day of week, month and a two-digit year. A free-running prescaler divides a 32.768 kHz clock-enable input down to a one-second strobe and a 1/64-second strobe. Hours run in either a 24-hour format or a 12-hour format with a separate afternoon flag. The day of month wraps at the length of the current month, and February takes its leap day when the year is a multiple of four.

A host reaches the block through a small register file of eight byte-wide locations: seven time fields and one control byte. Reads come back one clock after the address is presented. A hold input freezes the visible time so that a multi-byte read is coherent. A second that falls due during the hold is applied once the hold drops. Software can also issue a command that rounds the seconds to the nearest minute. A single interrupt line pulses at one of four selectable rates.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. When seconds wrap from 59 to 00, minutes advance. When minutes wrap, hours advance.
- R2: With control bit 0 clear (24-hour format), hours count 00 to 23. The step from 23 to 00 advances the day.
- R3: With control bit 0 set (12-hour format), hours run 12, 01, 02 … 11, 12. The afternoon flag is bit 7 of the hour register and inverts on every 11-to-12 step. The day advances only on the step where the flag goes from 1 to 0.
- R4: The day of month returns to 01 after the last day of the month. April, June, September and November have 30 days and February has 28. February has 29 days when the BCD year is a multiple of four. All other months have 31 days. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R5: The day of week counts 0 to 6, wraps to 0, and advances on every day change.
- R6: Writing the control register with bit 3 set clears seconds to 00. If the seconds were 30 or more, minutes advance with full carry. This command overrides a second advance in the same cycle, and bit 3 always reads back as 0.
- R7: One second elapses every 2^DIV_W asserted cycles of `tick_en`. The 1/64-second strobe fires every 2^(DIV_W-6) asserted cycles.
- R8: Control bits 2:1 select the interrupt rate: 0 for 1/64 second, 1 for every second, 2 when seconds wrap 59 to 00, and 3 when minutes wrap 59 to 00 on a counted second. `irq` is a one-cycle pulse, and the seconds and minutes wraps are flagged in the same cycle the new time appears.
- R9: A write to any of addresses 0 to 6 restarts the prescaler. The next second therefore completes a full 2^DIV_W ticks after the write, and any deferred second is discarded.
- R10: While `hold` is high the time fields do not change except by a host write or the rounding command. At most one second that falls due is kept and applied in the first cycle with `hold` low.
- R11: The register map is: 0 seconds, 1 minutes, 2 hour (bits 5:0) plus flag (bit 7), 3 day, 4 day of week, 5 month, 6 year, 7 control. `rd_data` is registered one cycle after `rd_addr`. Reset gives 00:00:00, day 01, weekday 0, month 01, year 00, control 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 32.768 kHz timebase enable, one cycle per tick |
| hold | input | 1 | Freezes the time fields for a coherent read |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Periodic interrupt pulse |

## Verification
The counters are driven across the boundaries where carries ripple furthest: the last second of a leap February, a non-leap February, the last second of a year in 12-hour format, and the noon and 1 PM steps. Together these separate the month-length, leap-year, afternoon-flag and year-wrap logic. Continuous and half-rate tick patterns show whether the prescaler counts enables or clocks. Rewriting the seconds mid-period shows whether a write restarts the prescaler. The rounding command is exercised both below and above 30 seconds, and the hold is held across two due seconds. Every interrupt rate is counted over a fixed window, and a behavioural model compares every read and interrupt cycle by cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC = 3'd0, A_MIN = 3'd1, A_HOUR = 3'd2, A_DAY = 3'd3,
    A_WDAY = 3'd4, A_MON = 3'd5, A_YEAR = 3'd6, A_CTRL = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    IRQ_TICK64 = 2'd0, IRQ_SEC = 2'd1, IRQ_MIN = 2'd2, IRQ_HOUR = 2'd3
  } irq_rate_e;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hr;
    logic       pm;
    logic [5:0] day;
    logic [2:0] dow;
    logic [4:0] mon;
    logic [7:0] yr;
  } tod_t;

  // Adds one to a two-digit BCD value (no wrap handling).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // A BCD year is a multiple of four when an even tens digit pairs with
  // units 0/4/8, or an odd tens digit pairs with units 2/6.
  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [5:0] days_in_month(input logic [4:0] mon,
                                               input logic [7:0] yr);
    case (mon)
      5'h02:                      return is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
  parameter int DIV_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic clr,
  output logic sec_stb,
  output logic frac_stb
);
  localparam int SUB_W = DIV_W - 6;

  logic [DIV_W-1:0] cnt_q;
  logic at_sub, at_full;

  assign at_sub  = &cnt_q[SUB_W-1:0];
  assign at_full = &cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q    <= '0;
      sec_stb  <= 1'b0;
      frac_stb <= 1'b0;
    end else if (tick_en) begin
      cnt_q    <= cnt_q + 1'b1;
      sec_stb  <= at_full;
      frac_stb <= at_sub;
    end else begin
      sec_stb  <= 1'b0;
      frac_stb <= 1'b0;
    end
  end

  // R7: a whole second always ends on a 1/64 boundary
  p_sec_on_frac_r7: assert property (@(posedge clk) disable iff (rst)
    sec_stb |-> frac_stb);

  // R9: a restart leaves no strobe behind
  p_clr_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!sec_stb && !frac_stb));
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sec_stb,
  input  logic        hold,
  input  logic        mode12,
  input  logic        wr_time,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        corr,
  output tod_t        tod_q,
  output logic        min_wrap,
  output logic        hr_wrap
);
  tod_t nxt;
  logic pend_q, advance;
  logic c_min, c_hr, c_day;
  logic [7:0] t_sec, t_min, t_hr, t_day, t_mon, t_yr;

  always_comb begin
    nxt     = tod_q;
    c_min   = 1'b0;
    c_hr    = 1'b0;
    c_day   = 1'b0;
    t_sec   = bcd_inc({1'b0, tod_q.sec});
    t_min   = bcd_inc({1'b0, tod_q.min});
    t_hr    = bcd_inc({2'b0, tod_q.hr});
    t_day   = bcd_inc({2'b0, tod_q.day});
    t_mon   = bcd_inc({3'b0, tod_q.mon});
    t_yr    = bcd_inc(tod_q.yr);
    advance = !hold && !wr_time && !corr && (sec_stb || pend_q);

    if (corr) begin
      nxt.sec = '0;
      c_min   = (tod_q.sec >= 7'h30);
    end else if (advance) begin
      if (tod_q.sec == 7'h59) begin
        nxt.sec = '0;
        c_min   = 1'b1;
      end else nxt.sec = t_sec[6:0];
    end

    if (c_min) begin
      if (tod_q.min == 7'h59) begin
        nxt.min = '0;
        c_hr    = 1'b1;
      end else nxt.min = t_min[6:0];
    end

    if (c_hr) begin
      if (mode12) begin
        if (tod_q.hr == 6'h12) nxt.hr = 6'h01;
        else if (tod_q.hr == 6'h11) begin
          nxt.hr = 6'h12;
          nxt.pm = !tod_q.pm;
          c_day  = tod_q.pm;
        end else nxt.hr = t_hr[5:0];
      end else begin
        if (tod_q.hr == 6'h23) begin
          nxt.hr = 6'h00;
          c_day  = 1'b1;
        end else nxt.hr = t_hr[5:0];
      end
    end

    if (c_day) begin
      nxt.dow = (tod_q.dow == 3'd6) ? 3'd0 : tod_q.dow + 3'd1;
      if (tod_q.day == days_in_month(tod_q.mon, tod_q.yr)) begin
        nxt.day = 6'h01;
        if (tod_q.mon == 5'h12) begin
          nxt.mon = 5'h01;
          nxt.yr  = (tod_q.yr == 8'h99) ? 8'h00 : t_yr;
        end else nxt.mon = t_mon[4:0];
      end else nxt.day = t_day[5:0];
    end

    min_wrap = advance && c_min;
    hr_wrap  = advance && c_hr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tod_q  <= '{sec: 7'h00, min: 7'h00, hr: 6'h00, pm: 1'b0,
                  day: 6'h01, dow: 3'd0, mon: 5'h01, yr: 8'h00};
      pend_q <= 1'b0;
    end else begin
      if (wr_time) begin
        case (reg_addr_e'(wr_addr))
          A_SEC:  tod_q.sec <= wr_data[6:0];
          A_MIN:  tod_q.min <= wr_data[6:0];
          A_HOUR: begin
            tod_q.hr <= wr_data[5:0];
            tod_q.pm <= wr_data[7];
          end
          A_DAY:  tod_q.day <= wr_data[5:0];
          A_WDAY: tod_q.dow <= wr_data[2:0];
          A_MON:  tod_q.mon <= wr_data[4:0];
          A_YEAR: tod_q.yr  <= wr_data;
          default: ;
        endcase
      end else begin
        tod_q <= nxt;
      end

      if (wr_time || corr)      pend_q <= 1'b0;
      else if (hold && sec_stb) pend_q <= 1'b1;
      else if (advance)         pend_q <= 1'b0;
    end
  end

  // R10: held time moves only through the host
  p_hold_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    (hold && !wr_time && !corr) |=> $stable(tod_q));

  // R6: rounding always lands on a whole minute
  p_round_zero_r6: assert property (@(posedge clk) disable iff (rst)
    corr |=> (tod_q.sec == 7'h00));

  // R5: a legal weekday stays legal unless rewritten
  p_wday_range_r5: assert property (@(posedge clk) disable iff (rst)
    (!wr_time && tod_q.dow <= 3'd6) |=> (tod_q.dow <= 3'd6));
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       hold,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq
);
  tod_t      tod;
  irq_rate_e sel_q;
  logic      mode12_q;
  logic      sec_stb, frac_stb, min_wrap, hr_wrap;
  logic      wr_time, wr_ctrl, corr;

  assign wr_ctrl = wr_en && (reg_addr_e'(wr_addr) == A_CTRL);
  assign wr_time = wr_en && !wr_ctrl;
  assign corr    = wr_ctrl && wr_data[3];

  rtc_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .tick_en(tick_en), .clr(wr_time),
    .sec_stb(sec_stb), .frac_stb(frac_stb)
  );

  rtc_time_core u_core (
    .clk(clk), .rst(rst), .sec_stb(sec_stb), .hold(hold), .mode12(mode12_q),
    .wr_time(wr_time), .wr_addr(wr_addr), .wr_data(wr_data), .corr(corr),
    .tod_q(tod), .min_wrap(min_wrap), .hr_wrap(hr_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode12_q <= 1'b0;
      sel_q    <= IRQ_TICK64;
      rd_data  <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        mode12_q <= wr_data[0];
        sel_q    <= irq_rate_e'(wr_data[2:1]);
      end
      case (sel_q)
        IRQ_TICK64: irq <= frac_stb;
        IRQ_SEC:    irq <= sec_stb;
        IRQ_MIN:    irq <= min_wrap;
        default:    irq <= hr_wrap;
      endcase
      case (reg_addr_e'(rd_addr))
        A_SEC:   rd_data <= {1'b0, tod.sec};
        A_MIN:   rd_data <= {1'b0, tod.min};
        A_HOUR:  rd_data <= {tod.pm, 1'b0, tod.hr};
        A_DAY:   rd_data <= {2'b0, tod.day};
        A_WDAY:  rd_data <= {5'b0, tod.dow};
        A_MON:   rd_data <= {3'b0, tod.mon};
        A_YEAR:  rd_data <= tod.yr;
        default: rd_data <= {5'b0, sel_q, mode12_q};
      endcase
    end
  end

  // R8: a per-second pulse needs a second strobe behind it
  p_irq_sec_src_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(sel_q) == IRQ_SEC) |-> $past(sec_stb));
endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb_top;
  localparam int DW  = 7;
  localparam int T   = 1 << DW;
  localparam int SUB = 1 << (DW - 6);

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0, hold = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_bcd_calendar #(.DIV_W(DW)) dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .hold(hold), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int m_cnt, m_sstb, m_fstb, m_pend, m_sec, m_min, m_hr, m_pm, m_day, m_dow;
  int m_mon, m_yr, m_m12, m_sel;
  logic [7:0] exp_rd;
  logic exp_irq, m_live = 1'b0;

  function automatic logic [7:0] enc(int d);
    return 8'((d / 10) * 16 + d % 10);
  endfunction
  function automatic int dec(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mlen(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] view(int a);
    case (a)
      0: return enc(m_sec);
      1: return enc(m_min);
      2: return enc(m_hr) | (m_pm != 0 ? 8'h80 : 8'h00);
      3: return enc(m_day);
      4: return 8'(m_dow);
      5: return enc(m_mon);
      6: return enc(m_yr);
      default: return 8'(m_sel * 2 + m_m12);
    endcase
  endfunction

  always @(posedge clk) begin
    int tw, co, adv, cm, ch, cd;
    if (rst) begin
      m_cnt = 0; m_sstb = 0; m_fstb = 0; m_pend = 0;
      m_sec = 0; m_min = 0; m_hr = 0; m_pm = 0; m_day = 1; m_dow = 0;
      m_mon = 1; m_yr = 0; m_m12 = 0; m_sel = 0;
      exp_rd = 0; exp_irq = 0; m_live = 1'b0;
    end else begin
      m_live = 1'b1;
      exp_rd = view(int'(rd_addr));
      tw  = (wr_en && wr_addr != 3'd7) ? 1 : 0;
      co  = (wr_en && wr_addr == 3'd7 && wr_data[3]) ? 1 : 0;
      adv = (!tw && !co && !hold && (m_sstb != 0 || m_pend != 0)) ? 1 : 0;
      cm = 0; ch = 0; cd = 0;
      if (co != 0) begin cm = (m_sec >= 30); m_sec = 0; end
      else if (adv != 0) begin
        if (m_sec == 59) begin m_sec = 0; cm = 1; end else m_sec++;
      end
      if (cm != 0) begin
        if (m_min == 59) begin m_min = 0; ch = 1; end else m_min++;
      end
      if (ch != 0) begin
        if (m_m12 != 0) begin
          if (m_hr == 12) m_hr = 1;
          else if (m_hr == 11) begin m_hr = 12; cd = m_pm; m_pm = 1 - m_pm; end
          else m_hr++;
        end else begin
          if (m_hr == 23) begin m_hr = 0; cd = 1; end else m_hr++;
        end
      end
      if (cd != 0) begin
        m_dow = (m_dow == 6) ? 0 : m_dow + 1;
        if (m_day == mlen(m_mon, m_yr)) begin
          m_day = 1;
          if (m_mon == 12) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
          else m_mon++;
        end else m_day++;
      end
      case (m_sel)
        0: exp_irq = (m_fstb != 0);
        1: exp_irq = (m_sstb != 0);
        2: exp_irq = (adv != 0 && cm != 0);
        default: exp_irq = (adv != 0 && ch != 0);
      endcase
      if (tw != 0 || co != 0) m_pend = 0;
      else if (hold && m_sstb != 0) m_pend = 1;
      else if (adv != 0) m_pend = 0;
      if (tw != 0) begin
        case (wr_addr)
          3'd0: m_sec = dec(wr_data & 8'h7F);
          3'd1: m_min = dec(wr_data & 8'h7F);
          3'd2: begin m_hr = dec(wr_data & 8'h3F); m_pm = int'(wr_data[7]); end
          3'd3: m_day = dec(wr_data & 8'h3F);
          3'd4: m_dow = int'(wr_data[2:0]);
          3'd5: m_mon = dec(wr_data & 8'h1F);
          default: m_yr = dec(wr_data);
        endcase
      end
      if (wr_en && wr_addr == 3'd7) begin
        m_m12 = int'(wr_data[0]); m_sel = int'(wr_data[2:1]);
      end
      if (tw != 0) begin m_cnt = 0; m_sstb = 0; m_fstb = 0; end
      else if (tick_en) begin
        m_sstb = (m_cnt == T - 1) ? 1 : 0;
        m_fstb = (m_cnt % SUB == SUB - 1) ? 1 : 0;
        m_cnt  = (m_cnt + 1) % T;
      end else begin m_sstb = 0; m_fstb = 0; end
    end
  end

  // Cycle-by-cycle comparison (R11 read path, R8 interrupt)
  always @(negedge clk) begin
    if (m_live && !done) begin
      checks += 2;
      if (rd_data !== exp_rd) begin
        failures++;
        $display("FAIL R11 cycle read addr model: actual=%h expected=%h", rd_data, exp_rd);
      end
      if (irq !== exp_irq) begin
        failures++;
        $display("FAIL R8 cycle irq model: actual=%0b expected=%0b", irq, exp_irq);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input int exp);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(tag, int'(rd_data), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stop_ticks();
    tick_en = 1'b0; idle(4);
  endtask

  task automatic count_irq(input int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (irq) c++; end
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, w, h, mi, s);
    wr(3'd6, y); wr(3'd5, mo); wr(3'd3, d); wr(3'd4, w);
    wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c;
    idle(3);
    @(negedge clk); rst = 1'b0;
    idle(2);
    // R11 reset state
    rd_chk("R11 reset sec", 3'd0, 8'h00);
    rd_chk("R11 reset hour", 3'd2, 8'h00);
    rd_chk("R11 reset day", 3'd3, 8'h01);
    rd_chk("R11 reset month", 3'd5, 8'h01);
    rd_chk("R11 reset ctrl", 3'd7, 8'h00);

    // R1 R2 R4 R5: leap February, 24-hour
    wr(3'd7, 8'h02);
    tick_en = 1'b1;
    set_time(8'h24, 8'h02, 8'h28, 8'h06, 8'h23, 8'h59, 8'h58);
    idle(2 * T + 10); stop_ticks();
    rd_chk("R1 seconds wrap", 3'd0, 8'h00);
    rd_chk("R1 minutes wrap", 3'd1, 8'h00);
    rd_chk("R2 hour 23 to 00", 3'd2, 8'h00);
    rd_chk("R4 leap Feb 29", 3'd3, 8'h29);
    rd_chk("R5 weekday wrap", 3'd4, 8'h00);
    tick_en = 1'b1;
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    idle(T + 10); stop_ticks();
    rd_chk("R4 leap end day", 3'd3, 8'h01);
    rd_chk("R4 leap end month", 3'd5, 8'h03);
    rd_chk("R5 weekday step", 3'd4, 8'h01);

    // R4 non-leap February
    tick_en = 1'b1;
    set_time(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    idle(T + 10); stop_ticks();
    rd_chk("R4 plain Feb day", 3'd3, 8'h01);
    rd_chk("R4 plain Feb month", 3'd5, 8'h03);

    // R3 R4: 12-hour format, year end
    wr(3'd7, 8'h01);
    tick_en = 1'b1;
    set_time(8'h99, 8'h12, 8'h31, 8'h02, 8'h91, 8'h59, 8'h59);
    idle(T + 10); stop_ticks();
    rd_chk("R3 11PM to 12AM", 3'd2, 8'h12);
    rd_chk("R4 year wrap", 3'd6, 8'h00);
    rd_chk("R4 Dec to Jan", 3'd5, 8'h01);
    rd_chk("R3 midnight day", 3'd3, 8'h01);
    tick_en = 1'b1;
    wr(3'd2, 8'h11); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    idle(T + 10); stop_ticks();
    rd_chk("R3 noon sets PM", 3'd2, 8'h92);
    rd_chk("R3 noon keeps day", 3'd3, 8'h01);
    tick_en = 1'b1;
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    idle(T + 10); stop_ticks();
    rd_chk("R3 12PM to 1PM", 3'd2, 8'h81);

    // R6 rounding
    wr(3'd7, 8'h02);
    wr(3'd3, 8'h15); wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h45);
    wr(3'd7, 8'h0A); idle(2);
    rd_chk("R6 round up sec", 3'd0, 8'h00);
    rd_chk("R6 round up carry hour", 3'd2, 8'h00);
    rd_chk("R6 round up carry day", 3'd3, 8'h16);
    rd_chk("R6 command bit reads 0", 3'd7, 8'h02);
    wr(3'd1, 8'h10); wr(3'd0, 8'h12);
    wr(3'd7, 8'h0A); idle(2);
    rd_chk("R6 round down sec", 3'd0, 8'h00);
    rd_chk("R6 round down min", 3'd1, 8'h10);

    // R10 hold
    tick_en = 1'b1;
    wr(3'd2, 8'h10); wr(3'd1, 8'h20); wr(3'd0, 8'h30);
    hold = 1'b1;
    idle(2 * T + T / 2);
    rd_chk("R10 frozen in hold", 3'd0, 8'h30);
    tick_en = 1'b0; hold = 1'b0; idle(4);
    rd_chk("R10 one deferred second", 3'd0, 8'h31);

    // R9 prescaler restart
    tick_en = 1'b1;
    wr(3'd0, 8'h00); idle(T / 2);
    wr(3'd0, 8'h00); idle(T / 2 + 5);
    rd_chk("R9 no early second", 3'd0, 8'h00);
    idle(T / 2);
    rd_chk("R9 full second", 3'd0, 8'h01);

    // R7 half-rate ticks
    wr(3'd0, 8'h00);
    for (int i = 0; i < 3 * T; i++) begin @(negedge clk); tick_en = ~tick_en; end
    stop_ticks();
    rd_chk("R7 counts enables", 3'd0, 8'h01);

    // R8 interrupt rates
    tick_en = 1'b1;
    wr(3'd7, 8'h00); idle(4);
    count_irq(T, c); chk("R8 rate 1/64", c, T / SUB);
    wr(3'd7, 8'h02); idle(2);
    count_irq(2 * T, c); chk("R8 rate second", c, 2);
    wr(3'd7, 8'h04); wr(3'd0, 8'h58);
    count_irq(3 * T, c); chk("R8 rate minute", c, 1);
    wr(3'd7, 8'h06); wr(3'd1, 8'h59); wr(3'd0, 8'h58);
    count_irq(3 * T, c); chk("R8 rate hour", c, 1);
    stop_ticks();

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule